// File: doc/BRIEF.md
# Per-Pin Byte-Mapped GPIO Array

This block gives software access to a large set of general-purpose pins, grouped into ports of equal width, over a plain synchronous register bus. Every pin owns one byte in the address map. A single byte write sets or clears that pin's output latch, so no read-modify-write is needed and two agents can never disturb each other's pins. Reading that byte returns exactly 0 or 1.

A second window holds one word per port that selects, bit by bit, which pins drive their pads. The pad side of the block is three flat vectors: pad inputs, pad output values and pad output enables. Each pad input passes through a two-stage synchroniser before it reaches the read path. A pin's byte therefore always reads the synchronised pad, whether the pin is being driven or not.

Bus reads take one cycle. The address is presented in one cycle and the data is registered at the next rising edge. Writes take effect at the rising edge on which `bus_we` is high.

Top module: `gpio_byte_array`

## Requirements
- R1: After reset every output latch and every direction bit is 0, so `pad_out` and `pad_oe` are all zero and every mapped location reads 0.
- R2: A write to byte offset n (n = port*32 + pin, 0..255) sets output latch n to 1 when `bus_wdata[7:0]` is nonzero and to 0 when it is zero. No other latch changes.
- R3: A read of byte offset n returns the synchronised pad value of pin n in bit 0, and bits 31..1 are zero.
- R4: A pad input change is seen through two flops. A read whose address is presented in the cycle the pad changes, or in the next cycle, returns the old value. A read presented two cycles after the change returns the new value.
- R5: The direction word of port p is at byte offset 0x2000 + 4*p. It is written with all 32 bits of `bus_wdata` and reads back as written. Bit k = 1 sets `pad_oe[p*32+k]`; bit k = 0 clears it.
- R6: `pad_out[n]` always equals latch n, whatever the pin's direction. A value written while the pin is an input is already on `pad_out` when the pin is turned to an output.
- R7: For a pin that is an output, a read of its byte returns the synchronised pad input, not the latch.
- R8: Offsets outside 0x0000..0x00FF and outside the aligned words 0x2000..0x201C read 0, and writes to them change no latch and no direction bit. This includes the unaligned offsets inside the direction window.
- R9: Read data appears on `bus_rdata` at the rising edge after the address is presented and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 14 | Byte offset from block base |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data; bits 7..0 for pin bytes, all bits for direction words |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pad_in | input | 256 | Pad input values, pin n at bit n |
| pad_out | output | 256 | Pad output values from the latches |
| pad_oe | output | 256 | Pad output enables from the direction words |

## Verification
The in-line properties check every cycle that:
- a pin-byte write lands in exactly the addressed latch with the right value;
- a direction write copies its word into the port's enables;
- a write to a hole leaves all pad outputs and enables steady;
- a pin read returns only bit 0;
- a hole reads 0;
- the synchroniser output is the pad input from two edges earlier.

Only the scenarios can show what a whole sequence produces:
- the exact cycle at which a pad change first becomes visible on the bus;
- that an enabled pin reads its pad rather than its latch;
- that a latch written while the pin is an input appears on the pad once the pin is enabled;
- that the unaligned direction offsets really are holes.

// File: rtl/gpio_arr_pkg.sv
package gpio_arr_pkg;

    // Which read source the current bus address selects
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PIN  = 2'd1,
        RSEL_DIR  = 2'd2
    } rsel_e;

    // A pin byte write drives 1 for any nonzero byte
    function automatic logic byte_to_level(input logic [7:0] b);
        return |b;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stage;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.meta  = async_in;
        st_d.stage = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage;

    // Checker state: edges since reset, saturating at 2
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R4: output is the pad value from two edges earlier
    a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] data_wr,
    input  logic            wr_level,
    input  logic            dir_wr,
    input  logic [PINS-1:0] dir_wdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pin_sync
);
    typedef struct packed {
        logic [PINS-1:0] latch;
        logic [PINS-1:0] dir;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < PINS; k++) begin
            if (data_wr[k]) st_d.latch[k] = wr_level;
        end
        if (dir_wr) st_d.dir = dir_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pad_out = st_q.latch;
    assign pad_oe  = st_q.dir;

    gpio_sync #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    // R2: the addressed latch takes the written level
    a_r2_pin_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_wr) |=> ((pad_out & $past(data_wr)) ==
                        ({PINS{$past(wr_level)}} & $past(data_wr))));

    // R2: latches move only when written
    a_r2_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr == '0) |=> $stable(pad_out));

    // R2: at most one pin of a port is written per cycle
    a_r2_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_wr));

    // R5: a direction write copies the word into the enables
    a_r5_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (pad_oe == $past(dir_wdata)));

endmodule

// File: rtl/gpio_byte_array.sv
module gpio_byte_array #(
    parameter int              NUM_PORTS     = 8,
    parameter int              PINS_PER_PORT = 32,
    parameter int              ADDR_W        = 14,
    parameter logic [13:0]     DIR_BASE      = 14'h2000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic                                  bus_we,
    input  logic [PINS_PER_PORT-1:0]              bus_wdata,
    output logic [PINS_PER_PORT-1:0]              bus_rdata,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0]    pad_in,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0]    pad_out,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0]    pad_oe
);
    import gpio_arr_pkg::*;

    localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;
    localparam int PIN_W    = $clog2(PINS_PER_PORT);
    localparam int PORT_W   = $clog2(NUM_PORTS);
    localparam int GPIN_W   = PIN_W + PORT_W;
    localparam int DATA_W   = PINS_PER_PORT;
    localparam logic [ADDR_W-1:0] PIN_END_A  = ADDR_W'(NUM_PINS);
    localparam logic [ADDR_W-1:0] DIR_BASE_A = ADDR_W'(DIR_BASE);
    localparam logic [ADDR_W-1:0] DIR_SPAN_A = ADDR_W'(4 * NUM_PORTS);

    // Address decode
    rsel_e              rsel;
    logic [ADDR_W-1:0]  dir_off;
    logic [GPIN_W-1:0]  gpin;
    logic [PORT_W-1:0]  dport;
    logic               wr_level;

    always_comb begin
        dir_off  = bus_addr - DIR_BASE_A;
        gpin     = bus_addr[GPIN_W-1:0];
        dport    = dir_off[2 +: PORT_W];
        wr_level = byte_to_level(bus_wdata[7:0]);
        if (bus_addr < PIN_END_A)
            rsel = RSEL_PIN;
        else if ((bus_addr >= DIR_BASE_A) && (dir_off < DIR_SPAN_A) &&
                 (bus_addr[1:0] == 2'b00))
            rsel = RSEL_DIR;
        else
            rsel = RSEL_NONE;
    end

    // Per-port write strobes and port instances
    logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] data_wr;
    logic [NUM_PORTS-1:0]                    dir_wr;
    logic [NUM_PINS-1:0]                     pin_sync;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_comb begin
            data_wr[p] = '0;
            if (bus_we && (rsel == RSEL_PIN) &&
                (gpin[GPIN_W-1:PIN_W] == PORT_W'(p)))
                data_wr[p][gpin[PIN_W-1:0]] = 1'b1;
            dir_wr[p] = bus_we && (rsel == RSEL_DIR) && (dport == PORT_W'(p));
        end

        gpio_port #(.PINS(PINS_PER_PORT)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .data_wr   (data_wr[p]),
            .wr_level  (wr_level),
            .dir_wr    (dir_wr[p]),
            .dir_wdata (bus_wdata),
            .pad_in    (pad_in  [p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pad_out   (pad_out [p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pad_oe    (pad_oe  [p*PINS_PER_PORT +: PINS_PER_PORT]),
            .pin_sync  (pin_sync[p*PINS_PER_PORT +: PINS_PER_PORT])
        );
    end

    // Registered read path
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t            st_d, st_q;
    logic [GPIN_W-1:0] dir_lsb;

    always_comb begin
        dir_lsb = {dport, {PIN_W{1'b0}}};
        st_d    = st_q;
        case (rsel)
            RSEL_PIN: st_d.rdata = DATA_W'(pin_sync[gpin]);
            RSEL_DIR: st_d.rdata = pad_oe[dir_lsb +: DATA_W];
            default:  st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R3: a pin byte read carries only bit 0
    a_r3_pin_read_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < PIN_END_A) |=> (bus_rdata[DATA_W-1:1] == '0));

    // R8: holes read zero
    a_r8_hole_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr >= PIN_END_A) && !((bus_addr >= DIR_BASE_A) &&
         (dir_off < DIR_SPAN_A) && (bus_addr[1:0] == 2'b00)))
        |=> (bus_rdata == '0));

    // R8: hole writes leave pads untouched
    a_r8_hole_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (rsel == RSEL_NONE)) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

// File: tb/gpio_byte_array_bench.sv
module gpio_byte_array_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [13:0]  bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] pad_in = '0;
    logic [255:0] pad_out, pad_oe;

    logic [255:0] exp_out = '0;
    logic [255:0] exp_oe  = '0;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    gpio_byte_array u_gpio_byte_array (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk256(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares one registered read per cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            chk32(it.tag, bus_rdata, it.exp);
        end
    end

    // Driver: present address, expectation is due at the next negedge
    task automatic rd(logic [13:0] a, logic [31:0] exp, string tag);
        sb_item_t it;
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        @(posedge clk);
        #1;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(logic [13:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk256("R1 pad_out after reset", pad_out, '0);
        chk256("R1 pad_oe after reset", pad_oe, '0);
        rd(14'h2000, 32'h0, "R1 dir word 0 after reset");
        rd(14'h0005, 32'h0, "R1 pin 5 after reset");
        drain();

        // R2: nonzero byte sets, zero clears, only that latch
        wr(14'h0025, 32'h0000_00A5); exp_out[37] = 1'b1;
        chk256("R2 write A5 to pin 37", pad_out, exp_out);
        wr(14'h00FF, 32'h0000_0080); exp_out[255] = 1'b1;
        chk256("R2 write 80 to pin 255", pad_out, exp_out);
        wr(14'h0025, 32'hFFFF_FF00); exp_out[37] = 1'b0;
        chk256("R2 zero low byte clears pin 37", pad_out, exp_out);
        wr(14'h0025, 32'h0000_0001); exp_out[37] = 1'b1;
        chk256("R2 write 01 to pin 37", pad_out, exp_out);

        // R5: direction words
        wr(14'h2004, 32'h0000_0020); exp_oe[37] = 1'b1;
        chk256("R5 port 1 dir bit 5", pad_oe, exp_oe);
        rd(14'h2004, 32'h0000_0020, "R5 read dir port 1");
        drain();
        wr(14'h201C, 32'hFFFF_0000); exp_oe[255:240] = '1;
        chk256("R5 port 7 upper half", pad_oe, exp_oe);
        rd(14'h201C, 32'hFFFF_0000, "R5 read dir port 7");
        drain();

        // R6: latch written while input appears once enabled
        chk256("R6 pad_out keeps latch of enabled pin 255", pad_out, exp_out);
        wr(14'h0003, 32'h0000_0001); exp_out[3] = 1'b1;
        chk256("R6 latch on pad_out while input", pad_out, exp_out);
        wr(14'h2000, 32'h0000_0008); exp_oe[3] = 1'b1;
        chk256("R6 pad_out after turning pin 3 on", pad_out, exp_out);
        chk256("R6 pad_oe after turning pin 3 on", pad_oe, exp_oe);

        // R7: output pin reads the pad, not the latch
        pad_in[37] = 1'b0;
        settle();
        rd(14'h0025, 32'h0, "R7 output pin 37 latch 1 pad 0");
        pad_in[37] = 1'b1;
        settle();
        rd(14'h0025, 32'h1, "R7 output pin 37 pad 1");
        drain();

        // R3: input pin reads exactly 0 or 1
        pad_in[200] = 1'b1;
        settle();
        rd(14'h00C8, 32'h1, "R3 input pin 200 high");
        rd(14'h00C9, 32'h0, "R3 input pin 201 low");
        drain();

        // R4/R9: visibility after exactly two synchroniser flops
        rd(14'h0064, 32'h0, "R9 pin 100 before change");
        pad_in[100] = 1'b1;
        rd(14'h0064, 32'h0, "R4 pin 100 same cycle");
        rd(14'h0064, 32'h0, "R4 pin 100 one cycle later");
        rd(14'h0064, 32'h1, "R4 pin 100 two cycles later");
        drain();

        // R8: holes read 0, writes ignored
        rd(14'h0100, 32'h0, "R8 read 0x0100");
        rd(14'h2020, 32'h0, "R8 read past dir window");
        rd(14'h2005, 32'h0, "R8 read unaligned dir offset");
        rd(14'h3FFF, 32'h0, "R8 read top offset");
        drain();
        wr(14'h0100, 32'hFFFF_FFFF);
        wr(14'h2020, 32'hFFFF_FFFF);
        wr(14'h2002, 32'hFFFF_FFFF);
        wr(14'h1FFF, 32'hFFFF_FFFF);
        chk256("R8 hole writes pad_out", pad_out, exp_out);
        chk256("R8 hole writes pad_oe", pad_oe, exp_oe);
        rd(14'h2000, 32'h0000_0008, "R8 dir port 0 unchanged");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule